// File: doc/BRIEF.md
# Digital Correlated Double Sampler

This block sits behind the ADC of a CCD video chain that takes many samples during each pixel period. It turns that sample stream into one noise-reduced value per pixel using a differential-averager scheme. A strobe that comes with a sample marks the first sample of a pixel. From that point a sample index splits the period into five parts: a reference window, a settling gap, the charge-dump interval, a second settling gap and a signal window. Samples in the reference window are added to an accumulator. Samples in the signal window are subtracted from it. Samples in the gaps and the dump interval do not touch it.

The number of samples per pixel comes from a run-time input, so the pixel rate can change. All window positions are derived from that count when a pixel starts. The accumulated difference is divided by the window length and kept with eight fractional bits, so averaging gives a result finer than one ADC code. Each result comes with a one-cycle valid pulse.

Top module: `dcds_pixel`

## Requirements
- R1: On a sample with `pix_start`, the samples-per-pixel input N is clamped to 12..256 and latched. From it the block derives the window length L = floor(35·N/100), the gap length G = floor(5·N/100) and the dump length D = floor(20·N/100).
- R2: The sample that comes with `pix_start` and `smp_valid` has index 0. Each later cycle with `smp_valid` high advances the index by one. Cycles with `smp_valid` low neither advance the index nor change the accumulation.
- R3: Samples with index in [0, L) are weighted +1. Samples with index in [S, S+L), where S = L+2G+D, are weighted -1. Samples in the gaps and the dump interval do not affect the result.
- R4: The result is (reference sum − signal sum)·256 / L, truncated toward zero. It is a signed two's-complement value with 8 fractional bits and SAMPLE_W+9 bits wide. Samples are unsigned codes.
- R5: `pix_valid` is high for exactly one cycle. That cycle is the clock after the sample with index S+L−1. `pix_value` changes only at such a pulse and holds its value between pulses.
- R6: A `pix_start` that comes before a pixel has finished throws away the partial sums and begins a new pixel. The aborted pixel produces no pulse.
- R7: Samples after the signal window, and samples that come while no pixel is open, are ignored until the next `pix_start`. They produce no pulse and leave `pix_value` unchanged.
- R8: The accumulator cannot overflow, even with full-scale codes filling a window of the largest length.
- R9: After reset, `pix_valid` is 0 and `pix_value` is 0, and no pixel is open.
- R10: A change of N while a pixel is running has no effect on that pixel's windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_spp | input | 9 | Samples per pixel, sampled at pixel start |
| smp_valid | input | 1 | An ADC sample is present this cycle |
| pix_start | input | 1 | The present sample is the first of a pixel |
| smp_data | input | 12 | Unsigned ADC code |
| pix_valid | output | 1 | One-cycle result strobe |
| pix_value | output | 21 | Signed result with 8 fractional bits |

## Verification
The bench builds the block with its default parameters: 12-bit samples, at most 256 samples per pixel and 8 fractional bits. With these values the sweep can cover every legal samples-per-pixel setting, from 12 to 256, so every floor-rounded boundary pattern of the windows is compared against arithmetic done in the bench. The same settings let full-scale codes fill the longest window of 89 samples, which drives the accumulator and the output to their extremes in both signs. Directed pixels then add the remaining cases: input stalls, aborts early and late in a pixel, out-of-range counts, a count change during a pixel, and ignored tail samples.

// File: rtl/dcds_pkg.sv
package dcds_pkg;

  localparam int unsigned MIN_SPP  = 12;
  localparam int unsigned PCT_WIN  = 35;
  localparam int unsigned PCT_GAP  = 5;
  localparam int unsigned PCT_DUMP = 20;

  typedef enum logic [1:0] {
    PH_NONE   = 2'd0,
    PH_RESET  = 2'd1,
    PH_SKIP   = 2'd2,
    PH_SIGNAL = 2'd3
  } dcds_phase_e;

  // Bring a requested samples-per-pixel value into the legal range.
  function automatic int unsigned clamp_spp(int unsigned n, int unsigned nmax);
    if (n < MIN_SPP) return MIN_SPP;
    if (n > nmax)    return nmax;
    return n;
  endfunction

  // Rounded-down percentage of a sample count.
  function automatic int unsigned part_of(int unsigned n, int unsigned pct);
    return (n * pct) / 100;
  endfunction

endpackage

// File: rtl/dcds_window_timer.sv
module dcds_window_timer
  import dcds_pkg::*;
#(
  parameter int NMAX  = 256,
  parameter int SPP_W = 9,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SPP_W-1:0] cfg_spp,
  input  logic             smp_valid,
  input  logic             pix_start,
  output dcds_phase_e      phase,
  output logic             start_evt,
  output logic             last_evt,
  output logic [IDX_W-1:0] win_len
);

  logic [IDX_W-1:0] idx_q;
  logic             active_q;
  logic [IDX_W-1:0] len_q, sbeg_q, send_q;

  int unsigned      n_eff, w_len, g_len, d_len;
  logic [IDX_W-1:0] len_new, sbeg_new, send_new;

  always_comb begin
    n_eff    = clamp_spp(32'(cfg_spp), NMAX);
    w_len    = part_of(n_eff, PCT_WIN);
    g_len    = part_of(n_eff, PCT_GAP);
    d_len    = part_of(n_eff, PCT_DUMP);
    len_new  = IDX_W'(w_len);
    sbeg_new = IDX_W'(w_len + 2 * g_len + d_len);
    send_new = IDX_W'(2 * w_len + 2 * g_len + d_len);
  end

  assign start_evt = smp_valid && pix_start;
  assign last_evt  = smp_valid && !pix_start && active_q &&
                     (idx_q == send_q - IDX_W'(1));
  assign win_len   = len_q;

  always_comb begin
    phase = PH_NONE;
    if (start_evt)
      phase = PH_RESET;
    else if (smp_valid && active_q) begin
      if (idx_q < len_q)
        phase = PH_RESET;
      else if (idx_q >= sbeg_q && idx_q < send_q)
        phase = PH_SIGNAL;
      else
        phase = PH_SKIP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
      len_q    <= '0;
      sbeg_q   <= '0;
      send_q   <= '0;
    end else if (start_evt) begin
      idx_q    <= IDX_W'(1);
      active_q <= 1'b1;
      len_q    <= len_new;
      sbeg_q   <= sbeg_new;
      send_q   <= send_new;
    end else if (smp_valid && active_q) begin
      idx_q <= idx_q + IDX_W'(1);
      if (last_evt) active_q <= 1'b0;
    end
  end

  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (idx_q == IDX_W'(1)) && active_q); // R6
  AST_IDX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(idx_q)); // R2
  AST_CFG_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !start_evt |=> $stable(len_q) && $stable(send_q)); // R10
  AST_WINDOWS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (send_q - sbeg_q == len_q) && (sbeg_q >= len_q)); // R3

endmodule

// File: rtl/dcds_accum.sv
module dcds_accum
  import dcds_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20,
  parameter int LMAX     = 89
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  dcds_phase_e             phase,
  input  logic                    start_evt,
  input  logic [SAMPLE_W-1:0]     smp_data,
  output logic signed [ACC_W-1:0] acc_next
);

  localparam logic signed [ACC_W-1:0] BOUND =
    ACC_W'(((2 ** SAMPLE_W) - 1) * LMAX);

  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] smp_ext;

  assign smp_ext = $signed({{(ACC_W-SAMPLE_W){1'b0}}, smp_data});

  always_comb begin
    unique case (phase)
      PH_RESET:  acc_next = (start_evt ? '0 : acc_q) + smp_ext;
      PH_SIGNAL: acc_next = acc_q - smp_ext;
      default:   acc_next = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_next;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= BOUND) && (acc_q >= -BOUND)); // R8
  AST_SKIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SKIP) |=> $stable(acc_q)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_NONE) |=> $stable(acc_q)); // R7

endmodule

// File: rtl/dcds_scaler.sv
module dcds_scaler #(
  parameter int ACC_W  = 20,
  parameter int IDX_W  = 9,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = 21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    last_evt,
  input  logic signed [ACC_W-1:0] diff,
  input  logic [IDX_W-1:0]        win_len,
  output logic                    pix_valid,
  output logic signed [OUT_W-1:0] pix_value
);

  localparam int EXT_W = ACC_W + FRAC_W;

  // Average with FRAC_W fractional bits, truncated toward zero.
  function automatic logic signed [OUT_W-1:0] scale_diff(
    logic signed [ACC_W-1:0] d, logic [IDX_W-1:0] len);
    logic signed [EXT_W-1:0] num, den, quo;
    num = EXT_W'(d) <<< FRAC_W;
    den = $signed({{(EXT_W-IDX_W){1'b0}}, len});
    if (len == '0) quo = '0;
    else           quo = num / den;
    return quo[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid <= 1'b0;
      pix_value <= '0;
    end else begin
      pix_valid <= last_evt;
      if (last_evt) pix_value <= scale_diff(diff, win_len);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> !pix_valid); // R5
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(last_evt)); // R5
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last_evt |=> $stable(pix_value)); // R7

endmodule

// File: rtl/dcds_pixel.sv
module dcds_pixel
  import dcds_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NMAX     = 256,
  parameter int FRAC_W   = 8,
  localparam int SPP_W   = $clog2(NMAX + 1),
  localparam int OUT_W   = SAMPLE_W + FRAC_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SPP_W-1:0]        cfg_spp,
  input  logic                    smp_valid,
  input  logic                    pix_start,
  input  logic [SAMPLE_W-1:0]     smp_data,
  output logic                    pix_valid,
  output logic signed [OUT_W-1:0] pix_value
);

  localparam int IDX_W = SPP_W;
  localparam int LMAX  = (35 * NMAX) / 100;
  localparam int ACC_W = SAMPLE_W + $clog2(LMAX + 1) + 1;

  dcds_phase_e             phase;
  logic                    start_evt, last_evt;
  logic [IDX_W-1:0]        win_len;
  logic signed [ACC_W-1:0] acc_next;

  dcds_window_timer #(.NMAX(NMAX), .SPP_W(SPP_W), .IDX_W(IDX_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cfg_spp(cfg_spp), .smp_valid(smp_valid),
    .pix_start(pix_start), .phase(phase), .start_evt(start_evt),
    .last_evt(last_evt), .win_len(win_len)
  );

  dcds_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .LMAX(LMAX)) u_accum (
    .clk(clk), .rst_n(rst_n), .phase(phase), .start_evt(start_evt),
    .smp_data(smp_data), .acc_next(acc_next)
  );

  dcds_scaler #(.ACC_W(ACC_W), .IDX_W(IDX_W), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_scaler (
    .clk(clk), .rst_n(rst_n), .last_evt(last_evt), .diff(acc_next),
    .win_len(win_len), .pix_valid(pix_valid), .pix_value(pix_value)
  );

  AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !pix_valid); // R6

endmodule

// File: tb/tb_dcds_pixel.sv
`timescale 1ns/1ps
module tb_dcds_pixel;
  localparam int SAMPLE_W = 12;
  localparam int OUT_W    = 21;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [8:0] cfg_spp = 9'd12;
  logic smp_valid = 1'b0;
  logic pix_start = 1'b0;
  logic [SAMPLE_W-1:0] smp_data = '0;
  logic pix_valid;
  logic signed [OUT_W-1:0] pix_value;

  always #4 clk = ~clk;

  dcds_pixel dut (
    .clk(clk), .rst_n(rst_n), .cfg_spp(cfg_spp), .smp_valid(smp_valid),
    .pix_start(pix_start), .smp_data(smp_data), .pix_valid(pix_valid),
    .pix_value(pix_value)
  );

  int total = 0;
  int bad = 0;
  bit exp_v = 1'b0;
  longint exp_val = 0;
  longint held_val = 0;
  string cur_tag = "R9";
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic next_rand(output logic [SAMPLE_W-1:0] d);
    seed = seed * 32'd1103515245 + 32'd12345;
    d = seed[27:16];
  endtask

  // One cycle: check what the previous edge produced, then drive.
  task automatic tick(bit v, bit st, logic [SAMPLE_W-1:0] d);
    @(negedge clk);
    chk(pix_valid == exp_v, cur_tag, "pix_valid", longint'(pix_valid), longint'(exp_v));
    if (exp_v && pix_valid) begin
      chk(longint'(pix_value) == exp_val, cur_tag, "pix_value", longint'(pix_value), exp_val);
      held_val = exp_val;
    end
    exp_v = 1'b0;
    smp_valid = v;
    pix_start = st;
    smp_data  = d;
  endtask

  function automatic int clampn(int n);
    if (n < 12) return 12;
    if (n > 256) return 256;
    return n;
  endfunction

  function automatic longint expect_out(longint d, int l);
    longint a, q;
    a = (d < 0) ? -d : d;
    q = (a * 256) / l;
    return (d < 0) ? -q : q;
  endfunction

  // mode: 0 random, 1 reference full scale, 2 signal full scale, 3 constant
  task automatic run_pixel(int ncfg, int mode, int stall_every, int abort_at,
                           int cfg_alt, int extra, string tag);
    int n, wl, gl, dl, sb, se;
    longint sum;
    logic [SAMPLE_W-1:0] d;
    n  = clampn(ncfg);
    wl = (n * 35) / 100;
    gl = (n * 5) / 100;
    dl = (n * 20) / 100;
    sb = wl + 2 * gl + dl;
    se = sb + wl;
    sum = 0;
    cur_tag = tag;
    cfg_spp = 9'(ncfg);
    for (int i = 0; i < n; i++) begin
      if (abort_at > 0 && i == abort_at) return;
      case (mode)
        1: d = (i < wl) ? 12'hFFF : 12'h000;
        2: d = (i >= sb) ? 12'hFFF : 12'h000;
        3: d = 12'd2000;
        default: next_rand(d);
      endcase
      if (i < wl) sum += longint'(d);
      else if (i >= sb && i < se) sum -= longint'(d);
      tick(1'b1, i == 0, d);
      if (i == 1 && cfg_alt > 0) cfg_spp = 9'(cfg_alt);
      if (i == se - 1) begin
        exp_v = 1'b1;
        exp_val = expect_out(sum, wl);
      end
      if (stall_every > 0 && (i % stall_every) == stall_every - 1) tick(1'b0, 1'b0, 12'h5A5);
    end
    for (int k = 0; k < extra; k++) begin
      next_rand(d);
      tick(1'b1, 1'b0, d);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [SAMPLE_W-1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pix_valid == 1'b0, "R9", "pix_valid in reset", longint'(pix_valid), 0);
    chk(pix_value == '0, "R9", "pix_value in reset", longint'(pix_value), 0);
    rst_n = 1'b1;

    // R7/R9: samples with no open pixel give nothing
    cur_tag = "R7";
    for (int k = 0; k < 40; k++) begin
      next_rand(d);
      tick(1'b1, 1'b0, d);
    end
    tick(1'b0, 1'b0, 12'h0);
    chk(pix_value == '0, "R9", "pix_value idle", longint'(pix_value), 0);

    // R1/R3/R4: every legal samples-per-pixel value
    for (int n = 12; n <= 256; n++) run_pixel(n, 0, 0, 0, 0, 1, "R1");

    // R1: out-of-range counts clamp
    run_pixel(5, 0, 0, 0, 0, 2, "R1");
    run_pixel(400, 0, 0, 0, 0, 2, "R1");

    // R3: constant input, reference and signal cancel exactly
    run_pixel(100, 3, 0, 0, 0, 2, "R3");

    // R4: full-scale positive at the shortest pixel
    run_pixel(12, 1, 0, 0, 0, 2, "R4");

    // R8: full scale both signs at the longest window
    run_pixel(256, 1, 0, 0, 0, 1, "R8");
    run_pixel(256, 2, 0, 0, 0, 1, "R8");

    // R2: stalls between samples
    run_pixel(37, 0, 3, 0, 0, 2, "R2");
    run_pixel(200, 0, 2, 0, 0, 2, "R2");

    // R6: aborts early and inside the signal window, then a clean pixel
    run_pixel(80, 0, 0, 30, 0, 0, "R6");
    run_pixel(50, 0, 0, 47, 0, 0, "R6");
    run_pixel(80, 0, 0, 0, 0, 1, "R6");

    // R10: count changes during a pixel
    run_pixel(60, 0, 0, 0, 200, 0, "R10");
    run_pixel(200, 0, 0, 0, 13, 0, "R10");

    // R7: long tail of extra samples is ignored
    run_pixel(30, 0, 0, 0, 0, 60, "R7");

    // R5: pulse then hold
    run_pixel(45, 0, 0, 0, 0, 0, "R5");
    tick(1'b0, 1'b0, 12'h0);
    tick(1'b0, 1'b0, 12'h0);
    chk(longint'(pix_value) == held_val, "R5", "pix_value held", longint'(pix_value), held_val);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule